// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the master state machine of a small 16-bit multi-cycle load/store processor. Each instruction moves through a series of states. The sequencer holds the current state and presents it as a 4-bit code, which the fetch, decode, execute, memory-access and writeback units use to time their work. The decoder supplies four steering fields: an instruction class, a flag that asks for the return address to be saved, a memory access mode and a load flag. The memory supplies a completion handshake. The sequencer branches on these inputs, but only in the states whose successor depends on them.

Any state that touches memory waits for the completion handshake. These states are instruction fetch, data read, data write and the indirect-pointer read, and each keeps its code until the handshake is high. All other states last exactly one cycle. The reset is synchronous and active high. It puts the machine back at instruction fetch.

Top module: `ctrl_sequencer`

## Requirements
- R1: While rst is high at a rising clock edge, the state after that edge is FETCH (code 0).
- R2: In FETCH (0), RDMEM (5), WRMEM (6) and INDIR (7), the state is held while mem_done is 0, whatever the other inputs are.
- R3: From FETCH with mem_done = 1, the next state is DECODE (1).
- R4: From DECODE, instr_class selects the next state: 0 gives ALU (2), 1 gives TARGET (3), 2 gives MADDR (4), and 3 gives INVALID (15).
- R5: From TARGET, save_pc = 1 gives UPDRF (8) and save_pc = 0 gives UPDPC (9).
- R6: From MADDR, mem_mode selects the next state: 0 gives RDMEM, 1 gives WRMEM, 2 gives INDIR, and 3 gives UPDRF.
- R7: From INDIR with mem_done = 1, load_flag = 1 gives RDMEM and load_flag = 0 gives WRMEM.
- R8: These transitions are fixed: ALU goes to UPDRF, RDMEM with mem_done goes to UPDRF, WRMEM with mem_done goes to UPDPC, UPDRF goes to UPDPC, and UPDPC goes to FETCH. None of them depends on the steering inputs.
- R9: INVALID returns to FETCH on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_done | input | 1 | Memory completion handshake |
| instr_class | input | 2 | Instruction class from the decoder |
| save_pc | input | 1 | Request to save the return address |
| mem_mode | input | 2 | Memory access mode from the decoder |
| load_flag | input | 1 | After an indirect read: 1 = read, 0 = write |
| state_o | output | 4 | Current state code |

## Verification
The assertions check on every cycle that reset lands in FETCH, that a memory-wait state holds while the handshake is low, that DECODE and TARGET reach only their allowed successors, and that INVALID and UPDPC fall through to FETCH. Only the bench scenarios can show that every value of each steering field picks its exact successor, and that an input is ignored in the states that do not branch on it. To show this, the bench runs the machine through long random walks, with a reference transition function, forced stalls and mid-run resets.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int STATE_W = 4;
    localparam int CLASS_W = 2;
    localparam int MODE_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ALU     = 4'd2,
        ST_TARGET  = 4'd3,
        ST_MADDR   = 4'd4,
        ST_RDMEM   = 4'd5,
        ST_WRMEM   = 4'd6,
        ST_INDIR   = 4'd7,
        ST_UPDRF   = 4'd8,
        ST_UPDPC   = 4'd9,
        ST_INVALID = 4'd15
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/seq_branch_sel.sv
module seq_branch_sel
    import seq_pkg::*;
(
    input  logic [CLASS_W-1:0] instr_class,
    input  logic               save_pc,
    input  logic [MODE_W-1:0]  mem_mode,
    input  logic               load_flag,
    output seq_state_e         after_decode,
    output seq_state_e         after_target,
    output seq_state_e         after_maddr,
    output seq_state_e         after_indir
);

    always_comb begin
        case (instr_class)
            2'd0:    after_decode = ST_ALU;
            2'd1:    after_decode = ST_TARGET;
            2'd2:    after_decode = ST_MADDR;
            default: after_decode = ST_INVALID;
        endcase
    end

    always_comb begin
        after_target = save_pc ? ST_UPDRF : ST_UPDPC;
    end

    always_comb begin
        case (mem_mode)
            2'd0:    after_maddr = ST_RDMEM;
            2'd1:    after_maddr = ST_WRMEM;
            2'd2:    after_maddr = ST_INDIR;
            default: after_maddr = ST_UPDRF;
        endcase
    end

    always_comb begin
        after_indir = load_flag ? ST_RDMEM : ST_WRMEM;
    end

endmodule

// File: rtl/seq_wait_detect.sv
module seq_wait_detect
    import seq_pkg::*;
(
    input  seq_state_e state,
    output logic       mem_wait
);

    always_comb begin
        case (state)
            ST_FETCH, ST_RDMEM, ST_WRMEM, ST_INDIR: mem_wait = 1'b1;
            default:                                mem_wait = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctrl_sequencer.sv
module ctrl_sequencer
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_done,
    input  logic [CLASS_W-1:0] instr_class,
    input  logic               save_pc,
    input  logic [MODE_W-1:0]  mem_mode,
    input  logic               load_flag,
    output logic [STATE_W-1:0] state_o
);

    seq_regs_t  r_d, r_q;
    seq_state_e after_decode, after_target, after_maddr, after_indir;
    logic       mem_wait;

    seq_branch_sel u_branch (
        .instr_class (instr_class),
        .save_pc     (save_pc),
        .mem_mode    (mem_mode),
        .load_flag   (load_flag),
        .after_decode(after_decode),
        .after_target(after_target),
        .after_maddr (after_maddr),
        .after_indir (after_indir)
    );

    seq_wait_detect u_wait (
        .state   (r_q.state),
        .mem_wait(mem_wait)
    );

    always_comb begin
        r_d = r_q;
        if (mem_wait && !mem_done) begin
            r_d.state = r_q.state;
        end else begin
            case (r_q.state)
                ST_FETCH:  r_d.state = ST_DECODE;
                ST_DECODE: r_d.state = after_decode;
                ST_ALU:    r_d.state = ST_UPDRF;
                ST_TARGET: r_d.state = after_target;
                ST_MADDR:  r_d.state = after_maddr;
                ST_RDMEM:  r_d.state = ST_UPDRF;
                ST_WRMEM:  r_d.state = ST_UPDPC;
                ST_INDIR:  r_d.state = after_indir;
                ST_UPDRF:  r_d.state = ST_UPDPC;
                ST_UPDPC:  r_d.state = ST_FETCH;
                default:   r_d.state = ST_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_FETCH;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;

    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (state_o == ST_FETCH));

    p_mem_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o inside {ST_FETCH, ST_RDMEM, ST_WRMEM, ST_INDIR} && !mem_done)
        |=> $stable(state_o));

    p_fetch_done_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_FETCH && mem_done) |=> (state_o == ST_DECODE));

    p_decode_succ_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DECODE)
        |=> (state_o inside {ST_ALU, ST_TARGET, ST_MADDR, ST_INVALID}));

    p_target_succ_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_TARGET) |=> (state_o inside {ST_UPDRF, ST_UPDPC}));

    p_maddr_indir_r6: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_MADDR && mem_mode == 2'd2) |=> (state_o == ST_INDIR));

    p_indir_succ_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_INDIR && mem_done) |=> (state_o inside {ST_RDMEM, ST_WRMEM}));

    p_updpc_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_UPDPC) |=> (state_o == ST_FETCH));

    p_invalid_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_INVALID) |=> (state_o == ST_FETCH));

endmodule

// File: tb/ctrl_sequencer_tb_top.sv
module ctrl_sequencer_tb_top;

    localparam logic [3:0] S_FETCH   = 4'd0;
    localparam logic [3:0] S_DECODE  = 4'd1;
    localparam logic [3:0] S_ALU     = 4'd2;
    localparam logic [3:0] S_TARGET  = 4'd3;
    localparam logic [3:0] S_MADDR   = 4'd4;
    localparam logic [3:0] S_RDMEM   = 4'd5;
    localparam logic [3:0] S_WRMEM   = 4'd6;
    localparam logic [3:0] S_INDIR   = 4'd7;
    localparam logic [3:0] S_UPDRF   = 4'd8;
    localparam logic [3:0] S_UPDPC   = 4'd9;
    localparam logic [3:0] S_INVALID = 4'd15;
    localparam int NCYC = 4000;

    logic       clk = 1'b0;
    logic       rst;
    logic       mem_done;
    logic [1:0] instr_class;
    logic       save_pc;
    logic [1:0] mem_mode;
    logic       load_flag;
    logic [3:0] state_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    ctrl_sequencer dut_i (
        .clk        (clk),
        .rst        (rst),
        .mem_done   (mem_done),
        .instr_class(instr_class),
        .save_pc    (save_pc),
        .mem_mode   (mem_mode),
        .load_flag  (load_flag),
        .state_o    (state_o)
    );

    function automatic logic [3:0] model_next(logic [3:0] s, logic d, logic [1:0] c,
                                              logic sp, logic [1:0] m, logic ld);
        case (s)
            S_FETCH:  return d ? S_DECODE : S_FETCH;
            S_DECODE: return (c == 2'd0) ? S_ALU : (c == 2'd1) ? S_TARGET :
                             (c == 2'd2) ? S_MADDR : S_INVALID;
            S_ALU:    return S_UPDRF;
            S_TARGET: return sp ? S_UPDRF : S_UPDPC;
            S_MADDR:  return (m == 2'd0) ? S_RDMEM : (m == 2'd1) ? S_WRMEM :
                             (m == 2'd2) ? S_INDIR : S_UPDRF;
            S_RDMEM:  return d ? S_UPDRF : S_RDMEM;
            S_WRMEM:  return d ? S_UPDPC : S_WRMEM;
            S_INDIR:  return d ? (ld ? S_RDMEM : S_WRMEM) : S_INDIR;
            S_UPDRF:  return S_UPDPC;
            S_UPDPC:  return S_FETCH;
            default:  return S_FETCH;
        endcase
    endfunction

    function automatic string req_tag(logic [3:0] s, logic d);
        if ((s == S_FETCH || s == S_RDMEM || s == S_WRMEM || s == S_INDIR) && !d) return "R2";
        case (s)
            S_FETCH:   return "R3";
            S_DECODE:  return "R4";
            S_TARGET:  return "R5";
            S_MADDR:   return "R6";
            S_INDIR:   return "R7";
            S_INVALID: return "R9";
            default:   return "R8";
        endcase
    endfunction

    logic [3:0] exp_state;
    string      exp_tag;

    initial begin
        #1ms;
        n_fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; mem_done = 1'b0; instr_class = 2'd0;
        save_pc = 1'b0; mem_mode = 2'd0; load_flag = 1'b0;
        exp_state = S_FETCH;
        exp_tag = "R1";
        void'($urandom(32'd7321));
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            logic       r_v, d_v, sp_v, ld_v;
            logic [1:0] c_v, m_v;
            @(negedge clk);
            n_checks++;
            if (state_o !== exp_state) begin
                n_fails++;
                $display("FAIL %s cycle %0d: state actual %0d expected %0d",
                         exp_tag, cyc, state_o, exp_state);
            end
            r_v  = (cyc < 2) || ((cyc % 900) >= 450 && (cyc % 900) < 452);
            d_v  = (($urandom % 3) != 0);
            c_v  = 2'($urandom);
            sp_v = 1'($urandom);
            m_v  = 2'($urandom);
            ld_v = 1'($urandom);
            if (cyc >= 1000 && cyc < 1040) d_v = 1'b0;
            if (cyc >= 1500 && cyc < 1530) c_v = 2'd3;
            if (cyc >= 1600 && cyc < 1660) begin c_v = 2'd2; m_v = 2'd3; end
            if (cyc >= 1700 && cyc < 1800) begin c_v = 2'd2; m_v = 2'd2; end
            exp_tag   = r_v ? "R1" : req_tag(exp_state, d_v);
            exp_state = r_v ? S_FETCH : model_next(exp_state, d_v, c_v, sp_v, m_v, ld_v);
            rst = r_v; mem_done = d_v; instr_class = c_v;
            save_pc = sp_v; mem_mode = m_v; load_flag = ld_v;
        end
        @(negedge clk);
        n_checks++;
        if (state_o !== exp_state) begin
            n_fails++;
            $display("FAIL %s final: state actual %0d expected %0d", exp_tag, state_o, exp_state);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule